// File: doc/BRIEF.md
# Serial EEPROM Bus Target

This block sits on a two-wire open-drain bus as a target that behaves like a small serial EEPROM holding 256 bytes. It samples the clock and data lines through a two-stage synchronizer and finds start, repeated start and stop conditions. It answers only the fixed 7-bit device identifier. It pulls the data line low only through an output enable, either to acknowledge or to return read data. The pad drives low whenever the enable is high.

The first byte after the address selects the word pointer. Data bytes that follow are stored at the pointer, and the pointer advances inside the current 16-byte page. A read started with a repeated start returns bytes from the pointer. The pointer then advances across the whole array for as long as the controller acknowledges. A debug output shows the pointer at all times.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe` is 0 and `addr_dbg` is 0.
- R2: A control byte of 1010000 followed by R/W=0 (the byte 0xA0, sent MSB first) is acknowledged. `sda_oe` is high during the ninth clock high phase. Every address byte and write-data byte is acknowledged in the same way.
- R3: A control byte whose upper seven bits differ from 1010000 gets no acknowledge. `sda_oe` stays 0 for every later clock until the next start condition, and the pointer is unchanged.
- R4: In a write, the byte after the control byte loads the pointer. Each acknowledged data byte is stored at the pointer.
- R5: During a write the pointer increments only in its low 4 bits, so it wraps to the start of its 16-byte page. Its upper 4 bits are kept.
- R6: A random read is start, 0xA0, word address, repeated start, then 0xA1 (R/W=1). It returns the byte stored at that address, MSB first.
- R7: During a read the pointer advances by one per byte sent, over the full 8-bit range, so 0xFF is followed by 0x00. After each byte the controller ACKs, the next byte is returned.
- R8: A controller NACK ends a read. The target keeps `sda_oe` at 0 afterwards, and the pointer is left one past the last byte returned.
- R9: A stop condition in the middle of a data byte discards that byte. Storage and the pointer keep their earlier values.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high the pad pulls the data line low |
| addr_dbg | output | 8 | Current word pointer |

## Verification
A write commit and a bus-condition abort compete for the same storage cell. A byte is stored only on the falling clock edge that ends its acknowledge. A stop seen after only some of the bits of that byte must cancel the commit and leave the pointer where it was. The bench sends five bits of a data byte to a cell that already holds a known value, then issues a stop. It then reads the cell back and the pointer, and expects the old values.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [6:0] DEV_ID    = 7'b1010000,
  parameter int         AW        = 8,
  parameter int         PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [AW-1:0] addr_dbg
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDATA, S_READ, S_SKIP} st_t;

  st_t         state;
  logic [2:0]  scl_sy, sda_sy;
  logic [3:0]  bitcnt;
  logic        ack_ph, mack;
  logic [7:0]  shreg, txreg;
  logic [AW-1:0] ptr;
  logic [7:0]  mem [DEPTH];

  wire scl_s = scl_sy[1];
  wire scl_p = scl_sy[2];
  wire sda_s = sda_sy[1];
  wire sda_p = sda_sy[2];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  wire [7:0]    rd_byte   = mem[ptr];
  wire [AW-1:0] page_next = {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
  wire          wr_en     = (state == S_WDATA) && ack_ph && scl_fall && !start_c && !stop_c;

  assign addr_dbg = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      mack   <= 1'b1;
      shreg  <= '0;
      txreg  <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_CTRL;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_CTRL, S_ADDR, S_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8 && !ack_ph) begin
            if (state == S_CTRL && shreg[7:1] != DEV_ID)
              state <= S_SKIP;
            else begin
              ack_ph <= 1'b1;
              sda_oe <= 1'b1;
            end
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              S_CTRL:
                if (shreg[0]) begin
                  state  <= S_READ;
                  txreg  <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  ptr    <= ptr + 1'b1;
                end else
                  state <= S_ADDR;
              S_ADDR: begin
                ptr   <= AW'(shreg);
                state <= S_WDATA;
              end
              default: ptr <= page_next;
            endcase
          end
        end
        S_READ: begin
          if (scl_fall && bitcnt < 4'd7) begin
            txreg  <= {txreg[6:0], 1'b0};
            sda_oe <= ~txreg[6];
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd8;
          end else if (scl_rise && bitcnt == 4'd8) begin
            mack <= sda_s;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (!mack) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
            end else
              state <= S_SKIP;
          end
        end
        default: ;
      endcase
    end

  AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10
  AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ph && scl_s && scl_p) |-> sda_oe); // R2
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe); // R3
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA && $past(state) == S_WDATA) |-> ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS])); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe); // R9
endmodule

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
  localparam int Q = 16;
  localparam logic [15:0] VEC [6] = '{16'h05_3C, 16'h50_11, 16'h7F_E7,
                                      16'h80_5A, 16'hC3_00, 16'h9A_96};
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [7:0] addr_dbg;
  wire sda_line = sda_m & ~sda_oe;

  i2c_eeprom_target u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
                        .sda_oe(sda_oe), .addr_dbg(addr_dbg));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, bad_oe = 0;
  logic oe_prev = 0, oe_seen = 0, finished = 0, oe_after = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always @(negedge clk) begin
    if (sda_oe !== oe_prev && scl_m) bad_oe++;
    if (sda_oe) oe_seen = 1;
    oe_prev = sda_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic bus_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(2); scl_m = 0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1; q(); scl_m = 1; q(); ack = ~sda_line; q(); scl_m = 0; q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1; q(); b = {b[6:0], sda_line}; q(); scl_m = 0;
    end
    q(); sda_m = ~give_ack; q(); scl_m = 1; q(2); scl_m = 0; q(); sda_m = 1;
  endtask

  task automatic page_write(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R2 ctrl ack", ack, 1);
    send_byte(a, ack);     chk(ack, "R2 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (!ack) chk(ack, "R2 data ack", ack, 1);
      model[{a[7:4], 4'(a[3:0] + i)}] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R6 ctrl ack", ack, 1);
    send_byte(a, ack);     chk(ack, "R6 addr ack", ack, 1);
    bus_start();
    send_byte(8'hA1, ack); chk(ack, "R6 read ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    q(); oe_after = sda_oe;
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] a;
    repeat (4) @(negedge clk);
    chk(sda_oe == 0, "R1 oe", sda_oe, 0);
    chk(addr_dbg == 0, "R1 ptr", addr_dbg, 0);
    rst_n = 1;
    q(2);

    for (int i = 0; i < 6; i++) begin
      a = VEC[i][15:8];
      wbuf[0] = VEC[i][7:0];
      page_write(a, 1);
      chk(addr_dbg == {a[7:4], 4'(a[3:0] + 1)}, "R4/R5 ptr after byte write", addr_dbg, {a[7:4], 4'(a[3:0] + 1)});
    end
    for (int i = 0; i < 6; i++) begin
      a = VEC[i][15:8];
      rand_read(a, 1);
      chk(rbuf[0] == VEC[i][7:0], "R4/R6 read data", rbuf[0], VEC[i][7:0]);
      chk(addr_dbg == 8'(a + 1), "R7 ptr after read", addr_dbg, 8'(a + 1));
    end

    // R3 foreign identifier
    oe_seen = 0;
    bus_start();
    send_byte(8'hA2, ack); chk(!ack, "R3 no ack for foreign id", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R3 later byte ignored", ack, 0);
    bus_stop();
    chk(!oe_seen, "R3 oe stayed low", oe_seen, 0);
    chk(addr_dbg == 8'h9B, "R3 ptr unchanged", addr_dbg, 8'h9B);

    // R5 page wrap: 18 bytes from 0x3E
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'hA0 + i);
    page_write(8'h3E, 18);
    chk(addr_dbg == 8'h30, "R5 ptr wrapped in page", addr_dbg, 8'h30);
    rand_read(8'h30, 16);
    for (int i = 0; i < 16; i++)
      chk(rbuf[i] == model[8'h30 + i], "R5/R7 page content", rbuf[i], model[8'h30 + i]);
    chk(rbuf[14] == 8'hB0, "R5 overwrite after wrap", rbuf[14], 8'hB0);

    // R7/R8 wrap across top of array
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    page_write(8'hFE, 2);
    wbuf[0] = 8'hC3;
    page_write(8'h00, 1);
    rand_read(8'hFE, 3);
    chk(rbuf[0] == 8'hC1 && rbuf[1] == 8'hC2 && rbuf[2] == 8'hC3, "R7 wrap read",
        {rbuf[0], rbuf[1], rbuf[2]}, 24'hC1C2C3);
    chk(oe_after == 0, "R8 released after nack", oe_after, 0);
    chk(addr_dbg == 8'h01, "R8 ptr after nack", addr_dbg, 8'h01);

    // R9 stop in the middle of a data byte
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h50, ack);
    send_bits(8'h99, 5);
    scl_m = 0;
    bus_stop();
    chk(addr_dbg == 8'h50, "R9 ptr not advanced", addr_dbg, 8'h50);
    rand_read(8'h50, 1);
    chk(rbuf[0] == 8'h11, "R9 cell kept", rbuf[0], 8'h11);

    chk(bad_oe == 0, "R10 oe change with scl high", bad_oe, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule